// File: doc/BRIEF.md
# Cross-Coupled Toggle State Machine

This block is a two-bit clocked state machine. Each state bit sits in its own toggle flip-flop, and fixed combinational logic drives the toggle inputs from the two data inputs and the present state. The logic that feeds each flip-flop reads the other flip-flop, so the two bits are cross-coupled and the block does not count.

A Mealy output is formed combinationally from one data input and one state bit. Each state bit has its own asynchronous force-high and force-low lines, which are used to load any starting state. An active-low asynchronous reset clears both bits. Both state bits are brought out so that the state can be observed.

Top module: `tt_machine`

## Requirements
- R1: While rst_ni is low, a_o and b_o are 0 without waiting for a clock edge.
- R2: On each rising edge of clk_i, bit A inverts when (x1_i AND b_o) is 1 and keeps its value otherwise.
- R3: On each rising edge of clk_i, bit B inverts when (x2_i OR a_o) is 1 and keeps its value otherwise.
- R4: y_o equals x1_i AND NOT b_o at all times. It follows input changes within the same cycle, with no clock edge needed.
- R5: A high on pre_a_i or pre_b_i drives the matching state bit to 1 at once, without waiting for the clock.
- R6: A high on clr_a_i or clr_b_i drives the matching state bit to 0 at once, without waiting for the clock.
- R7: When the force-low and force-high lines of a bit are both high, the bit is 0.
- R8: For every one of the 16 combinations of present state {a_o,b_o} and inputs {x1_i,x2_i}, the next state and y_o match the equations of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears both bits |
| pre_a_i | input | 1 | Asynchronous force-high for bit A |
| clr_a_i | input | 1 | Asynchronous force-low for bit A; overrides pre_a_i |
| pre_b_i | input | 1 | Asynchronous force-high for bit B |
| clr_b_i | input | 1 | Asynchronous force-low for bit B; overrides pre_b_i |
| x1_i | input | 1 | Data input 1 |
| x2_i | input | 1 | Data input 2 |
| y_o | output | 1 | Mealy output |
| a_o | output | 1 | Present value of state bit A |
| b_o | output | 1 | Present value of state bit B |

## Verification
The assertions check, on every clock edge, three properties of each flip-flop:
- it inverts after a cycle in which its toggle input was high;
- it holds its value after a cycle in which its toggle input was low;
- its force lines win, with force-low taking priority.

Only the bench scenarios can show two other behaviours. First, the forcing and the reset act between clock edges. Second, the cross-coupled toggle equations and the output equation match their arithmetic definition across all 16 state and input cases.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned N_STATE = 2;
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;
  typedef logic [N_STATE-1:0] state_t;
endpackage

// File: rtl/tt_toggle_ff.sv
module tt_toggle_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_i,
  input  logic clr_i,
  input  logic t_i,
  output logic q_o
);
  // force-low beats force-high beats toggle
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i or posedge pre_i) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (pre_i) q_o <= 1'b1;
    else if (t_i)   q_o <= ~q_o;
  end

  // R2/R3: toggle behaviour of each state bit
  p_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i || pre_i)
    t_i |=> (q_o != $past(q_o)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i || pre_i)
    !t_i |=> $stable(q_o));
  p_clr_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_o);
  p_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !clr_i) |-> q_o);
endmodule

// File: rtl/tt_next_logic.sv
module tt_next_logic
  import tt_pkg::*;
(
  input  state_t st_i,
  input  logic   x1_i,
  input  logic   x2_i,
  output state_t tog_o
);
  always_comb begin
    tog_o        = '0;
    tog_o[IDX_A] = x1_i & st_i[IDX_B];
    tog_o[IDX_B] = x2_i | st_i[IDX_A];
  end
endmodule

// File: rtl/tt_out_logic.sv
module tt_out_logic
  import tt_pkg::*;
(
  input  state_t st_i,
  input  logic   x1_i,
  output logic   y_o
);
  assign y_o = x1_i & ~st_i[IDX_B];
endmodule

// File: rtl/tt_machine.sv
module tt_machine
  import tt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_a_i,
  input  logic clr_a_i,
  input  logic pre_b_i,
  input  logic clr_b_i,
  input  logic x1_i,
  input  logic x2_i,
  output logic y_o,
  output logic a_o,
  output logic b_o
);
  state_t st, tog, pre_v, clr_v;

  assign pre_v[IDX_A] = pre_a_i;
  assign pre_v[IDX_B] = pre_b_i;
  assign clr_v[IDX_A] = clr_a_i;
  assign clr_v[IDX_B] = clr_b_i;

  tt_next_logic u_next (.st_i(st), .x1_i(x1_i), .x2_i(x2_i), .tog_o(tog));

  for (genvar i = 0; i < N_STATE; i++) begin : g_ff
    tt_toggle_ff u_ff (
      .clk_i(clk_i), .rst_ni(rst_ni), .pre_i(pre_v[i]), .clr_i(clr_v[i]),
      .t_i(tog[i]), .q_o(st[i])
    );
  end

  tt_out_logic u_out (.st_i(st), .x1_i(x1_i), .y_o(y_o));

  assign a_o = st[IDX_A];
  assign b_o = st[IDX_B];

  // R8: A moves only when X1 is high and B was high
  p_a_needs_x1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_a_i || pre_a_i)
    !(x1_i && b_o) |=> $stable(a_o));
endmodule

// File: tb/tt_machine_bench.sv
`timescale 1ns/1ps
module tt_machine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pre_a = 0, clr_a = 0, pre_b = 0, clr_b = 0, x1 = 0, x2 = 0;
  logic y, a, b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tt_machine u_tt_machine (
    .clk_i(clk), .rst_ni(rst_n), .pre_a_i(pre_a), .clr_a_i(clr_a),
    .pre_b_i(pre_b), .clr_b_i(clr_b), .x1_i(x1), .x2_i(x2),
    .y_o(y), .a_o(a), .b_o(b)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // force a state across one edge, then release mid-cycle
  task automatic load(input logic sa, input logic sb);
    @(negedge clk);
    pre_a = sa; clr_a = !sa; pre_b = sb; clr_b = !sb;
    #1 chk("R5/R6 force", {1'b0, a, b}, {1'b0, sa, sb});
    @(negedge clk);
    pre_a = 0; clr_a = 0; pre_b = 0; clr_b = 0;
  endtask

  initial begin
    #2 chk("R1 reset", {y, a, b}, 3'b000);
    #20 rst_n = 1'b1;
    // R7: clear beats preset on both bits
    load(1'b1, 1'b1);
    @(negedge clk);
    pre_a = 1; clr_a = 1; pre_b = 1; clr_b = 1;
    #1 chk("R7 priority", {1'b0, a, b}, 3'b000);
    @(negedge clk);
    pre_a = 0; clr_a = 0; pre_b = 0; clr_b = 0;
    // R8: all 16 state/input cases
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 4; x++) begin
        logic sa, sb, i1, i2, na, nb, ey;
        sa = s[1]; sb = s[0]; i1 = x[1]; i2 = x[0];
        load(sa, sb);
        x1 = i1; x2 = i2;
        ey = i1 & ~sb;
        na = sa ^ (i1 & sb);
        nb = sb ^ (i2 | sa);
        #1 chk("R4 mealy", {y, a, b}, {ey, sa, sb});
        @(negedge clk);
        chk("R8 next/R2 R3", {1'b0, a, b}, {1'b0, na, nb});
        x1 = 0; x2 = 0;
      end
    end
    // R4: output follows inputs mid-cycle without an edge
    load(1'b0, 1'b0);
    #1 x1 = 1;
    #1 chk("R4 comb", {y, 2'b00}, 3'b100);
    x1 = 0;
    // R1: asynchronous reset mid-cycle
    load(1'b1, 1'b1);
    #1 rst_n = 0;
    #1 chk("R1 async", {1'b0, a, b}, 3'b000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule